// File: doc/BRIEF.md
# Slave Stereo Serial Audio Port

This block is the serial edge of a stereo audio datapath. Another device drives both the bit clock and the word clock. The receive half turns the serial input into 24-bit two's-complement words, one per channel. It hands each finished word to the internal datapath together with a one-cycle strobe and a flag that names the channel. The transmit half uses the same frame timing to shift words from the datapath back out in the same channel slots. A typical datapath is a delay line, so the output frame lines up with the input frame.

Everything runs in the bit-clock domain, and the incoming word-clock transitions alone drive the frame timing. Each channel half lasts 32 bit clocks. The most significant bit sits in the second bit period after a word-clock change. The 24 data bits follow MSB first, and the trailing slots are padding. Input is sampled on rising bit-clock edges and output changes on falling ones. The port does nothing until it has seen its first word-clock transition after reset.

Top module: `i2s_slave_port`

## Requirements
- R1: While reset is held and just after it is released, `rx_valid` is 0, `rx_word` is 0 and `sdout` is 0.
- R2: After a word-clock transition, the bit sampled on the second rising bit-clock edge (slot 1) is taken as bit 23 of the word. Slots 1 to 24 fill `rx_word` MSB first.
- R3: `rx_valid` pulses high for exactly one bit clock, right after the rising edge that samples slot 24. `rx_right` is 0 when the word clock was low (left channel) and 1 when it was high (right channel).
- R4: Input bits in slot 0 and in slots 25 to 31 of each half have no effect on `rx_word`.
- R5: `rx_word` keeps its value between strobes and changes only when `rx_valid` is asserted.
- R6: At each word-clock transition the transmitter loads `tx_left` if the word clock went low, or `tx_right` if it went high. It presents bit 23 on `sdout` for slot 1 and bit 0 for slot 24, changing `sdout` on falling edges only.
- R7: `sdout` is 0 during slot 0 and slots 25 to 31 of every half.
- R8: A change on `tx_left` or `tx_right` after the load has no effect on the word currently being shifted out.
- R9: After reset, neither strobes nor transmitted data appear until the first word-clock transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bck | input | 1 | Bit clock from the external master (64 per sample period) |
| rst_n | input | 1 | Active-low reset, synchronous to bck |
| lrck | input | 1 | Word clock, low = left channel, high = right channel |
| sdin | input | 1 | Serial data in, sampled on rising bck |
| tx_left | input | 24 | Left word from the datapath for transmission |
| tx_right | input | 24 | Right word from the datapath for transmission |
| sdout | output | 1 | Serial data out, updated on falling bck |
| rx_word | output | 24 | Last received channel word |
| rx_right | output | 1 | Channel of `rx_word` (1 = right) |
| rx_valid | output | 1 | One-cycle strobe for a new `rx_word` |

## Verification
The assertions assume a clean master. The word clock and serial input change only between rising edges, and every half frame gives at least 25 bit clocks after its transition, so the slot counter reaches slot 24 before the next channel begins. The bench plays the master role. It changes `lrck` and `sdin` just after falling edges, always produces full 32-clock halves, and changes the transmit words only a quarter period after rising edges, away from the falling edge where the transmitter loads them. Random data and random padding bits then cover the data-dependent paths within those limits.

// File: rtl/i2s_port_pkg.sv
package i2s_port_pkg;
  localparam int unsigned DEF_WORD_W  = 24;
  localparam int unsigned DEF_HALF_LEN = 32;

  // true when a slot index within one channel half carries a data bit
  function automatic logic is_data_slot(input int unsigned slot, input int unsigned word_w);
    return (slot >= 1) && (slot <= word_w);
  endfunction

  // bit index of the word carried by a data slot (slot 1 -> MSB)
  function automatic int unsigned slot_to_bit(input int unsigned slot, input int unsigned word_w);
    return word_w - slot;
  endfunction
endpackage

// File: rtl/i2s_frame_tracker.sv
module i2s_frame_tracker #(
  parameter int unsigned HALF_LEN = i2s_port_pkg::DEF_HALF_LEN,
  parameter int unsigned CNT_W    = $clog2(2 * HALF_LEN)
) (
  input  logic             bck,
  input  logic             rst_n,
  input  logic             lrck,
  output logic             frame_edge,
  output logic [CNT_W-1:0] cur_slot,
  output logic [CNT_W-1:0] slot_q,
  output logic             lr_q
);
  localparam logic [CNT_W-1:0] SLOT_SAT = CNT_W'(2 * HALF_LEN - 1);

  always_comb begin
    frame_edge = (lrck != lr_q);
    if (frame_edge)
      cur_slot = '0;
    else if (slot_q == SLOT_SAT)
      cur_slot = SLOT_SAT;
    else
      cur_slot = slot_q + CNT_W'(1);
  end

  always_ff @(posedge bck) begin
    if (!rst_n) begin
      lr_q   <= lrck;
      slot_q <= SLOT_SAT;
    end else begin
      lr_q   <= lrck;
      slot_q <= cur_slot;
    end
  end
endmodule

// File: rtl/i2s_rx_shifter.sv
module i2s_rx_shifter #(
  parameter int unsigned WORD_W = i2s_port_pkg::DEF_WORD_W,
  parameter int unsigned CNT_W  = 6
) (
  input  logic              bck,
  input  logic              rst_n,
  input  logic              sdin,
  input  logic              lrck,
  input  logic [CNT_W-1:0]  cur_slot,
  output logic              capture_done,
  output logic [WORD_W-1:0] rx_word,
  output logic              rx_right,
  output logic              rx_valid
);
  logic [WORD_W-2:0] shreg;
  logic              take_bit;

  always_comb begin
    take_bit     = i2s_port_pkg::is_data_slot(int'(cur_slot), WORD_W);
    capture_done = (cur_slot == CNT_W'(WORD_W));
  end

  always_ff @(posedge bck) begin
    if (!rst_n) begin
      shreg    <= '0;
      rx_word  <= '0;
      rx_right <= 1'b0;
      rx_valid <= 1'b0;
    end else begin
      if (take_bit)
        shreg <= {shreg[WORD_W-3:0], sdin};
      if (capture_done) begin
        rx_word  <= {shreg, sdin};
        rx_right <= lrck;
      end
      rx_valid <= capture_done;
    end
  end
endmodule

// File: rtl/i2s_tx_shifter.sv
module i2s_tx_shifter #(
  parameter int unsigned WORD_W = i2s_port_pkg::DEF_WORD_W,
  parameter int unsigned CNT_W  = 6
) (
  input  logic              bck,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  slot_q,
  input  logic              lr_q,
  input  logic [WORD_W-1:0] tx_left,
  input  logic [WORD_W-1:0] tx_right,
  output logic              sdout
);
  logic [WORD_W-1:0] txsh;
  logic [WORD_W-1:0] pick;
  logic              load_now;
  logic              shift_now;

  always_comb begin
    pick      = lr_q ? tx_right : tx_left;
    load_now  = (slot_q == '0);
    shift_now = i2s_port_pkg::is_data_slot(int'(slot_q), WORD_W - 1);
  end

  // falling edge: drive the bit for the slot whose rising edge comes next
  always_ff @(negedge bck) begin
    if (!rst_n) begin
      txsh  <= '0;
      sdout <= 1'b0;
    end else if (load_now) begin
      sdout <= pick[WORD_W-1];
      txsh  <= {pick[WORD_W-2:0], 1'b0};
    end else if (shift_now) begin
      sdout <= txsh[WORD_W-1];
      txsh  <= {txsh[WORD_W-2:0], 1'b0};
    end else begin
      sdout <= 1'b0;
    end
  end
endmodule

// File: rtl/i2s_slave_port.sv
module i2s_slave_port #(
  parameter int unsigned WORD_W   = i2s_port_pkg::DEF_WORD_W,
  parameter int unsigned HALF_LEN = i2s_port_pkg::DEF_HALF_LEN
) (
  input  logic              bck,
  input  logic              rst_n,
  input  logic              lrck,
  input  logic              sdin,
  input  logic [WORD_W-1:0] tx_left,
  input  logic [WORD_W-1:0] tx_right,
  output logic              sdout,
  output logic [WORD_W-1:0] rx_word,
  output logic              rx_right,
  output logic              rx_valid
);
  localparam int unsigned CNT_W = $clog2(2 * HALF_LEN);

  logic             frame_edge;
  logic [CNT_W-1:0] cur_slot;
  logic [CNT_W-1:0] slot_q;
  logic             lr_q;
  logic             capture_done;

  i2s_frame_tracker #(.HALF_LEN(HALF_LEN), .CNT_W(CNT_W)) u_track (
    .bck(bck), .rst_n(rst_n), .lrck(lrck),
    .frame_edge(frame_edge), .cur_slot(cur_slot), .slot_q(slot_q), .lr_q(lr_q)
  );

  i2s_rx_shifter #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_rx (
    .bck(bck), .rst_n(rst_n), .sdin(sdin), .lrck(lrck), .cur_slot(cur_slot),
    .capture_done(capture_done), .rx_word(rx_word), .rx_right(rx_right), .rx_valid(rx_valid)
  );

  i2s_tx_shifter #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_tx (
    .bck(bck), .rst_n(rst_n), .slot_q(slot_q), .lr_q(lr_q),
    .tx_left(tx_left), .tx_right(tx_right), .sdout(sdout)
  );
endmodule

// File: rtl/i2s_port_checker.sv
module i2s_port_checker #(
  parameter int unsigned WORD_W = 24,
  parameter int unsigned CNT_W  = 6
) (
  input logic              bck,
  input logic              rst_n,
  input logic              lrck,
  input logic              frame_edge,
  input logic [CNT_W-1:0]  slot_q,
  input logic              sdout,
  input logic [WORD_W-1:0] rx_word,
  input logic              rx_right,
  input logic              rx_valid
);
  assert_single_pulse_R3: assert property (@(posedge bck) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  assert_channel_flag_R3: assert property (@(posedge bck) disable iff (!rst_n)
    rx_valid |-> (rx_right == $past(lrck)));

  assert_word_hold_R5: assert property (@(posedge bck) disable iff (!rst_n)
    !$stable(rx_word) |-> rx_valid);

  assert_slot_restart_R2: assert property (@(posedge bck) disable iff (!rst_n)
    frame_edge |=> (slot_q == '0));

  assert_tx_quiet_R7: assert property (@(posedge bck) disable iff (!rst_n)
    (slot_q >= CNT_W'(WORD_W)) |-> !sdout);
endmodule

bind i2s_slave_port i2s_port_checker #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_chk (
  .bck(bck), .rst_n(rst_n), .lrck(lrck), .frame_edge(frame_edge), .slot_q(slot_q),
  .sdout(sdout), .rx_word(rx_word), .rx_right(rx_right), .rx_valid(rx_valid)
);

// File: tb/tb_i2s_slave_port.sv
`timescale 1ns/1ps
module tb_i2s_slave_port;
  localparam int W = 24;

  logic         bck = 1'b0;
  logic         rst_n = 1'b0;
  logic         lrck = 1'b0;
  logic         sdin = 1'b0;
  logic [W-1:0] tx_left = '0;
  logic [W-1:0] tx_right = '0;
  logic         sdout;
  logic [W-1:0] rx_word;
  logic         rx_right;
  logic         rx_valid;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 bck = ~bck;

  i2s_slave_port dut (
    .bck(bck), .rst_n(rst_n), .lrck(lrck), .sdin(sdin),
    .tx_left(tx_left), .tx_right(tx_right),
    .sdout(sdout), .rx_word(rx_word), .rx_right(rx_right), .rx_valid(rx_valid)
  );

  // bit the serial line must carry in slot j of a half carrying word w
  function automatic logic line_bit(input logic [W-1:0] w, input int j);
    if (j >= 1 && j <= W) return w[W - j];
    return 1'b0;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // one channel half of 32 slots; synced: port is locked to the frame
  task automatic send_half(input logic lr, input logic [W-1:0] word, input logic [31:0] pad,
                           input bit synced, input logic [W-1:0] tx_exp, input bit swap_mid);
    int tx_bad = 0;
    int tx_first_bad = -1;
    int stray = 0;
    for (int j = 0; j < 32; j++) begin
      @(negedge bck); #1;
      lrck = lr;
      sdin = (j >= 1 && j <= W) ? word[W - j] : pad[j];
      @(posedge bck); #5;
      if (synced && j == W) begin
        check(rx_valid === 1'b1, "R3", "strobe after slot 24", {31'd0, rx_valid}, 32'd1);
        check(rx_word === word, "R2", "received word", {8'd0, rx_word}, {8'd0, word});
        check(rx_right === lr, "R3", "channel flag", {31'd0, rx_right}, {31'd0, lr});
      end else if (rx_valid !== 1'b0) begin
        stray++;
      end
      if (sdout !== (synced ? line_bit(tx_exp, j) : 1'b0)) begin
        tx_bad++;
        if (tx_first_bad < 0) tx_first_bad = j;
      end
      if (swap_mid && j == 5) begin
        if (lr) tx_right = ~tx_right; else tx_left = ~tx_left;
      end
    end
    check(stray == 0, synced ? "R3" : "R9", "strobes outside slot 24", stray, 0);
    check(tx_bad == 0, synced ? "R6" : "R9", "sdout slot mismatches (R7 R8)", tx_bad, 0);
    if (synced)
      check(rx_word === word, "R5", "word held to end of half", {8'd0, rx_word}, {8'd0, word});
  endtask

  task automatic frame(input logic [W-1:0] lw, input logic [W-1:0] rw,
                       input logic [31:0] pl, input logic [31:0] pr,
                       input logic [W-1:0] tl, input logic [W-1:0] tr);
    tx_left = tl;
    send_half(1'b0, lw, pl, 1'b1, tl, 1'b0);
    tx_right = tr;
    send_half(1'b1, rw, pr, 1'b1, tr, 1'b0);
  endtask

  initial begin
    #4000000;
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] a, b, c, d;
    int unsigned seed_val;
    seed_val = $urandom(32'd20240611);
    tx_left = 24'hABCDEF;
    tx_right = 24'h123456;
    repeat (4) @(posedge bck);
    #5;
    // R1: outputs during reset
    check(rx_valid === 1'b0, "R1", "rx_valid in reset", {31'd0, rx_valid}, 0);
    check(rx_word === '0, "R1", "rx_word in reset", {8'd0, rx_word}, 0);
    check(sdout === 1'b0, "R1", "sdout in reset", {31'd0, sdout}, 0);
    @(negedge bck); #1; rst_n = 1'b1;
    @(posedge bck); #5;
    check(rx_valid === 1'b0 && sdout === 1'b0, "R1", "outputs after release",
          {30'd0, rx_valid, sdout}, 0);
    // R9: no word-clock transition yet -> nothing happens
    send_half(1'b0, 24'h5A5A5A, 32'hFFFFFFFF, 1'b0, '0, 1'b0);
    check(rx_word === '0, "R9", "no capture before sync", {8'd0, rx_word}, 0);
    // first transition locks the port (right half)
    tx_right = 24'h13579B;
    send_half(1'b1, 24'h2468AC, 32'h0, 1'b1, 24'h13579B, 1'b0);
    // R2 R6: extreme codes
    frame(24'h800000, 24'h7FFFFF, 32'h0, 32'h0, 24'h7FFFFF, 24'h800000);
    // R4: all-ones padding around zero words, then zero padding around ones
    frame(24'h000000, 24'h000000, 32'hFFFFFFFF, 32'hFFFFFFFF, 24'h000001, 24'h800001);
    frame(24'hFFFFFF, 24'hFFFFFF, 32'h0, 32'h0, 24'hFFFFFF, 24'h000000);
    // R8: change transmit word mid-shift, original must still go out
    tx_left = 24'hC3C3C3;
    send_half(1'b0, 24'h111111, 32'h0, 1'b1, 24'hC3C3C3, 1'b1);
    tx_right = 24'h0F0F0F;
    send_half(1'b1, 24'h222222, 32'h0, 1'b1, 24'h0F0F0F, 1'b1);
    // random traffic with random padding
    for (int k = 0; k < 40; k++) begin
      a = W'($urandom); b = W'($urandom); c = W'($urandom); d = W'($urandom);
      frame(a, b, $urandom, $urandom, c, d);
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule